// File: doc/BRIEF.md
# Delay-Locked Loop Tap Controller

This block is the digital control loop of a delay-locked loop. It runs on the reference clock and steers an 8-bit delay-line tap setting so that a feedback clock edge lines up with the reference edge. A phase detector outside the block reports, every reference cycle, whether the feedback arrived early, late or aligned. The controller moves the tap one step at a time toward alignment. After enough consecutive aligned samples it raises a locked flag.

Once locked, the controller ignores the detector except at a fixed update interval. At each such point it takes one trim step, which lets the loop follow slow temperature and voltage drift. If a step would take the tap past either end of its range, the loop gives up: locked falls, a sticky limit-error flag rises, and only a reset clears it.

The feedback may come from the 1X or the 2X clock output. In 2X mode the acquisition loop acts on every second detector sample. That gives the doubled feedback path time to settle. All pins are plain control and status signals. There is no data stream, so no valid/ready handshake applies.

Top module: `dll_tap_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, the tap output is mid-range (128 for 8 bits), locked is 0 and the limit error is 0.
- R2: During acquisition, an acted detector sample of code 2'b01 (feedback early) raises the tap by one, and code 2'b10 (feedback late) lowers it by one. The tap changes by at most one step per clock.
- R3: Locked rises only after LOCK_CNT consecutive acted samples of code 2'b00 (aligned). Any other acted code restarts the count. Locked is low throughout acquisition.
- R4: With the feedback select at 0 (1X), every cycle's sample is acted on. With it at 1 (2X), samples are acted on only at the 2nd, 4th, 6th, ... clock edges after reset release.
- R5: While locked, the detector is ignored except on every UPD_INTERVAL-th cycle counted from the lock edge. On those cycles one early or late step is taken, and locked stays high.
- R6: A step that would raise the tap above 255 or lower it below 0 clears locked, sets the limit error, and freezes the tap. From then on, detector inputs have no effect until reset.
- R7: Code 2'b11 is invalid. It never moves the tap, and during acquisition it restarts the aligned count.
- R8: Asserting reset at any time, including after a limit error, returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| pd_code_i | input | 2 | Phase detector code: 00 aligned, 01 early, 10 late, 11 invalid |
| fb_2x_i | input | 1 | Feedback select: 0 = 1X output, 1 = 2X output |
| tap_o | output | TAP_W | Delay-line tap setting |
| locked_o | output | 1 | Loop locked |
| lim_err_o | output | 1 | Sticky tap-range error |

## Verification
A periodic trim step and the range-limit check can fall in the same cycle. This happens when the update tick arrives while the tap already sits at 0 or 255 and the detector still asks for movement past it. The bench provokes this by locking the loop near the bottom of the range and then drifting the modelled target below zero. It judges the result cycle by cycle against a bench model: the error must rise exactly at the tick, locked must fall, and the tap must stay at 0. The same collision is also driven at the top end during acquisition, and it recurs under random targets and detector noise.

// File: rtl/dll_tap_pkg.sv
package dll_tap_pkg;
  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_LOCK  = 2'd1,
    ST_FAULT = 2'd2
  } dll_state_e;

  localparam logic [1:0] PD_ALIGNED = 2'b00;
  localparam logic [1:0] PD_EARLY   = 2'b01;
  localparam logic [1:0] PD_LATE    = 2'b10;
  localparam logic [1:0] PD_INVALID = 2'b11;
endpackage

// File: rtl/dll_step_gate.sv
// Qualifies detector samples: every cycle in 1X, every second cycle in 2X (R4).
module dll_step_gate (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic fb_2x_i,
  output logic act_o
);
  logic phase_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) phase_q <= 1'b0;
    else          phase_q <= ~phase_q;
  end

  assign act_o = ~fb_2x_i | phase_q;
endmodule

// File: rtl/dll_align_cnt.sv
// Counts consecutive aligned samples; done fires on the sample that completes the run (R3).
module dll_align_cnt #(
  parameter int LOCK_CNT = 8
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int CW = $clog2(LOCK_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CNT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i || clr_i) cnt_q <= '0;
    else if (inc_i)        cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = inc_i && (cnt_q == LAST);
endmodule

// File: rtl/dll_upd_timer.sv
// Periodic update tick while locked; restarts from zero whenever not running (R5).
module dll_upd_timer #(
  parameter int UPD_INTERVAL = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int TW = (UPD_INTERVAL > 1) ? $clog2(UPD_INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(UPD_INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_n_i || !run_i) cnt_q <= '0;
    else if (tick_o)        cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dll_tap_ctrl.sv
module dll_tap_ctrl
  import dll_tap_pkg::*;
#(
  parameter int TAP_W        = 8,
  parameter int LOCK_CNT     = 8,
  parameter int UPD_INTERVAL = 16
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [1:0]       pd_code_i,
  input  logic             fb_2x_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             locked_o,
  output logic             lim_err_o
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;
  localparam logic [TAP_W-1:0] TAP_MIN = '0;
  localparam logic [TAP_W-1:0] TAP_MID = {1'b1, {(TAP_W-1){1'b0}}};

  dll_state_e       state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             act, tick, step_ok, align_done;
  logic             is_early, is_late, is_aligned, hit_lim;
  logic             acq_inc, acq_clr;

  dll_step_gate u_gate (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .fb_2x_i (fb_2x_i),
    .act_o   (act)
  );

  dll_upd_timer #(.UPD_INTERVAL(UPD_INTERVAL)) u_timer (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .run_i   (state_q == ST_LOCK),
    .tick_o  (tick)
  );

  dll_align_cnt #(.LOCK_CNT(LOCK_CNT)) u_align (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .clr_i   (acq_clr),
    .inc_i   (acq_inc),
    .done_o  (align_done)
  );

  always_comb begin
    is_early   = (pd_code_i == PD_EARLY);
    is_late    = (pd_code_i == PD_LATE);
    is_aligned = (pd_code_i == PD_ALIGNED);
    unique case (state_q)
      ST_ACQ:  step_ok = act;
      ST_LOCK: step_ok = tick;
      default: step_ok = 1'b0;
    endcase
    hit_lim = step_ok && ((is_early && tap_q == TAP_MAX) ||
                          (is_late  && tap_q == TAP_MIN));
    acq_inc = (state_q == ST_ACQ) && step_ok && is_aligned;
    acq_clr = (state_q != ST_ACQ) || (step_ok && !is_aligned);
  end

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    if (state_q != ST_FAULT) begin
      if (hit_lim) begin
        state_d = ST_FAULT;
      end else if (step_ok && is_early) begin
        tap_d = tap_q + 1'b1;
      end else if (step_ok && is_late) begin
        tap_d = tap_q - 1'b1;
      end else if (state_q == ST_ACQ && align_done) begin
        state_d = ST_LOCK;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      state_q <= ST_ACQ;
      tap_q   <= TAP_MID;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
    end
  end

  assign tap_o     = tap_q;
  assign locked_o  = (state_q == ST_LOCK);
  assign lim_err_o = (state_q == ST_FAULT);
endmodule

// File: rtl/dll_tap_ctrl_chk.sv
module dll_tap_ctrl_chk #(
  parameter int TAP_W = 8
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic [1:0]       pd_code_i,
  input logic [TAP_W-1:0] tap_o,
  input logic             locked_o,
  input logic             lim_err_o
);
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tap_o == $past(tap_o)) || (tap_o == $past(tap_o) + 1'b1) ||
    (tap_o == $past(tap_o) - 1'b1)); // R2

  AST_LOCK_NEEDS_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(locked_o) |-> ($past(pd_code_i) == 2'b00)); // R3

  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    locked_o |=> (locked_o || lim_err_o)); // R5

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    lim_err_o |-> !locked_o); // R6

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    lim_err_o |=> (lim_err_o && $stable(tap_o))); // R6

  AST_INVALID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (pd_code_i == 2'b11) |=> $stable(tap_o)); // R7
endmodule

bind dll_tap_ctrl dll_tap_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n_i   (rst_n_i),
  .pd_code_i (pd_code_i),
  .tap_o     (tap_o),
  .locked_o  (locked_o),
  .lim_err_o (lim_err_o)
);

// File: tb/tb_dll_tap_ctrl.sv
`timescale 1ns/1ps
module tb_dll_tap_ctrl;
  localparam int TAP_W    = 8;
  localparam int LOCK_CNT = 8;
  localparam int UPD      = 16;
  localparam int TAP_PS   = 45;
  localparam int PER_PS   = 10000;
  localparam int PATH_PS  = 4000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       pd = 2'b00;
  logic             fb = 1'b0;
  logic [TAP_W-1:0] tap;
  logic             locked, err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int target = 0;
  int noise = 0;
  string tag = "R1";

  int m_state, m_tap, m_acnt, m_tcnt;
  bit m_tog;

  always #5 clk = ~clk;

  dll_tap_ctrl #(.TAP_W(TAP_W), .LOCK_CNT(LOCK_CNT), .UPD_INTERVAL(UPD)) dut (
    .clk_i(clk), .rst_n_i(rst_n), .pd_code_i(pd), .fb_2x_i(fb),
    .tap_o(tap), .locked_o(locked), .lim_err_o(err));

  function automatic int target_for(bit f2x, int per_ps);
    int p;
    p = f2x ? per_ps / 2 : per_ps;
    return (p - PATH_PS) / TAP_PS;
  endfunction

  function automatic logic [1:0] pd_for(int t, int tgt);
    if (t < tgt) return 2'b01;
    if (t > tgt) return 2'b10;
    return 2'b00;
  endfunction

  // bench model of R1..R8, advanced at each rising edge with the held inputs
  task automatic model_step();
    bit act, tick;
    if (!rst_n) begin
      m_state = 0; m_tap = 128; m_acnt = 0; m_tcnt = 0; m_tog = 0;
      return;
    end
    act = !fb || m_tog;
    m_tog = !m_tog;
    if (m_state == 0) begin
      m_tcnt = 0;
      if (act) begin
        if (pd == 2'b01) begin
          if (m_tap == 255) m_state = 2; else begin m_tap++; m_acnt = 0; end
        end else if (pd == 2'b10) begin
          if (m_tap == 0) m_state = 2; else begin m_tap--; m_acnt = 0; end
        end else if (pd == 2'b00) begin
          if (m_acnt == LOCK_CNT - 1) begin m_state = 1; m_acnt = 0; end
          else m_acnt++;
        end else m_acnt = 0;
      end
    end else if (m_state == 1) begin
      tick = (m_tcnt == UPD - 1);
      m_tcnt = tick ? 0 : m_tcnt + 1;
      if (tick) begin
        if (pd == 2'b01) begin
          if (m_tap == 255) m_state = 2; else m_tap++;
        end else if (pd == 2'b10) begin
          if (m_tap == 0) m_state = 2; else m_tap--;
        end
      end
    end
  endtask

  task automatic check(string rq, int act_v, int exp_v, string what);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", rq, what, act_v, exp_v, cycles);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, int'(tap), m_tap, "tap");
    check(tag, int'(locked), (m_state == 1) ? 1 : 0, "locked");
    check(tag, int'(err), (m_state == 2) ? 1 : 0, "limit error");
    pd = pd_for(int'(tap), target);
    if (noise > 0 && ($urandom % 100) < noise) pd = 2'($urandom % 4);
  endtask

  task automatic do_reset(bit f2x);
    rst_n = 1'b0; fb = f2x; pd = 2'b01;
    repeat (3) cycle();
    rst_n = 1'b1;
    pd = pd_for(int'(tap), target);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state held while reset low
    tag = "R1"; target = target_for(0, PER_PS);
    do_reset(0);
    check("R1", int'(tap), 128, "tap at reset");
    check("R1", int'(locked), 0, "locked at reset");
    check("R1", int'(err), 0, "error at reset");

    // R2 / R3: 1X acquisition to target 133 and lock
    tag = "R2";
    repeat (40) cycle();
    check("R3", int'(locked), 1, "locked after acquisition");
    check("R2", int'(tap), target, "tap at target");

    // R5: drift while locked, trims only on update ticks
    tag = "R5"; target = target + 3;
    repeat (100) cycle();
    check("R5", int'(tap), target, "tap tracked drift");
    check("R5", int'(locked), 1, "lock held through trims");

    // R7: invalid code mixed into acquisition
    tag = "R7"; target = 140; do_reset(0); noise = 40;
    repeat (200) cycle();
    noise = 0;

    // R4: 2X feedback, half period target, every second sample acted
    tag = "R4"; target = target_for(1, PER_PS); do_reset(1);
    repeat (260) cycle();
    check("R4", int'(locked), 1, "2X lock");
    check("R4", int'(tap), target, "2X target");

    // R6: upper limit during acquisition
    tag = "R6"; target = 300; do_reset(0);
    repeat (140) cycle();
    check("R6", int'(err), 1, "error at upper limit");
    check("R6", int'(tap), 255, "tap frozen at top");
    pd = 2'b10; cycle(); pd = 2'b10;
    check("R6", int'(tap), 255, "late ignored after error");

    // R8: reset clears the error
    tag = "R8"; target = 3; do_reset(0);
    check("R8", int'(err), 0, "error cleared by reset");
    check("R8", int'(tap), 128, "tap back to mid");

    // R6 lower limit hit by a periodic trim tick while locked
    tag = "R6"; repeat (150) cycle();
    check("R6", int'(locked), 1, "locked near bottom");
    target = -5;
    repeat (120) cycle();
    check("R6", int'(err), 1, "error on trim at bottom");
    check("R6", int'(tap), 0, "tap frozen at zero");

    // R2 constrained random: random mode, target, noise
    tag = "R2";
    for (int i = 0; i < 12; i++) begin
      target = int'($urandom % 281) - 10;
      noise = int'($urandom % 25);
      do_reset(bit'($urandom % 2));
      for (int k = 0; k < 350; k++) begin
        if (k == 200) target = target + int'($urandom % 9) - 4;
        cycle();
      end
    end
    noise = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule